// File: doc/BRIEF.md
# Block-Lookahead Binary Adder

This block adds two N-bit unsigned or two's-complement operands together with a carry input. It produces an N-bit sum and a carry output. The block is purely combinational. The operand width is divided into groups of K columns. For each group, one lookahead cell forms the group's generate and propagate terms from the per-column terms. A single AND-OR stage then sends the carry across the group boundary. Inside the group, a short chain of full adders produces the sum bits from the carry that enters that group.

The block is used wherever a wide add has to settle in less time than a full ripple chain needs. The worst-case carry path crosses N/K lookahead stages and then at most K full adders. A full ripple chain would cross N full adders. There is no state, no reset and no pipelining, so the outputs follow the inputs within the same cycle.

Top module: `cla_adder`

## Requirements
- R1: `{carry_out, sum}` equals the arithmetic value `op_a + op_b + carry_in`, taken as an (N+1)-bit unsigned result, for every input combination.
- R2: The carry that a group sends to the next group, formed as group-generate OR (group-propagate AND group carry-in), equals the carry out of that group's own full-adder chain.
- R3: When every column of a group propagates (for each column, at least one operand bit is 1) and no column generates, the group's carry in passes straight through to its carry out. For example, all-ones plus zero with carry_in=1 gives sum 0 and carry_out 1.
- R4: When a group generates, its carry out is 1 whatever its carry in is. For example, 0x0000000F + 0x00000001 gives 0x00000010, with the carry crossing from group 0 into group 1.
- R5: When a group neither generates nor propagates, its carry out is 0 even when its carry in is 1.
- R6: Operands with alternating bits (0xAAAAAAAA + 0x55555555) give an all-ones sum and carry_out 0 when carry_in=0. They give sum 0 and carry_out 1 when carry_in=1.
- R7: All-ones plus all-ones gives carry_out 1. The sum is all ones except bit 0, and bit 0 equals carry_in.
- R8: Zero operands with carry_in=0 give sum 0 and carry_out 0.
- R9: N must be an integer multiple of K. The carry out of the last group is the block's carry_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into column 0 |
| sum | output | N | Low N bits of the result |
| carry_out | output | 1 | Carry out of the top column |

## Verification
A wrong group-generate or group-propagate term sends a wrong carry into the next group. At the ports this shows up as an off-by-one error of 2^(K·j) in the sum, or as a flipped carry_out, on the same input vector. There are no registers in the block, so such an error appears in the same cycle as the vector that triggers it and disappears with the next vector. Vectors that put propagate runs across group boundaries (all ones, alternating bits, low-nibble carries) are therefore the ones that expose a wrong lookahead term. Random vectors cover the rest of the input space.

// File: rtl/cla_pkg.sv
package cla_pkg;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    // Combine an upper span with the lower span directly beneath it.
    function automatic gp_t gp_merge(input gp_t upper, input gp_t lower);
        gp_t r;
        r.gen  = upper.gen | (upper.prop & lower.gen);
        r.prop = upper.prop & lower.prop;
        return r;
    endfunction

endpackage

// File: rtl/cla_fa.sv
module cla_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
    end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [K-1:0] xa,
    input  logic [K-1:0] xb,
    input  logic         cin,
    output logic         grp_gen,
    output logic         grp_prop,
    output logic         cout
);
    gp_t col [K];
    gp_t acc [K];

    for (genvar i = 0; i < K; i++) begin : g_col
        assign col[i].gen  = xa[i] & xb[i];
        assign col[i].prop = xa[i] | xb[i];
    end

    assign acc[0] = col[0];
    for (genvar i = 1; i < K; i++) begin : g_fold
        assign acc[i] = gp_merge(col[i], acc[i-1]);
    end

    assign grp_gen  = acc[K-1].gen;
    assign grp_prop = acc[K-1].prop;
    assign cout     = grp_gen | (grp_prop & cin);

    always_comb begin
        if (!$isunknown({xa, xb, cin})) begin
            // R3: a fully propagating group passes its carry through
            a_r3_pass_through: assert (!(grp_prop && !grp_gen) || (cout == cin));
            // R4: a generating group always carries
            a_r4_generate: assert (!grp_gen || cout);
            // R5: a group that neither generates nor propagates kills the carry
            a_r5_kill: assert (grp_gen || grp_prop || !cout);
        end
    end
endmodule

// File: rtl/cla_ripple.sv
module cla_ripple #(
    parameter int K = 4
) (
    input  logic [K-1:0] xa,
    input  logic [K-1:0] xb,
    input  logic         cin,
    output logic [K-1:0] s,
    output logic         c_end
);
    logic [K:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < K; i++) begin : g_fa
        cla_fa u_fa (
            .x  (xa[i]),
            .y  (xb[i]),
            .ci (c[i]),
            .s  (s[i]),
            .co (c[i+1])
        );
    end

    assign c_end = c[K];
endmodule

// File: rtl/cla_group.sv
module cla_group #(
    parameter int K = 4
) (
    input  logic [K-1:0] xa,
    input  logic [K-1:0] xb,
    input  logic         cin,
    output logic [K-1:0] s,
    output logic         cout
);
    logic g_unused;
    logic p_unused;
    logic ripple_end;

    cla_lookahead #(.K(K)) u_la (
        .xa       (xa),
        .xb       (xb),
        .cin      (cin),
        .grp_gen  (g_unused),
        .grp_prop (p_unused),
        .cout     (cout)
    );

    cla_ripple #(.K(K)) u_rc (
        .xa    (xa),
        .xb    (xb),
        .cin   (cin),
        .s     (s),
        .c_end (ripple_end)
    );

    always_comb begin
        if (!$isunknown({xa, xb, cin})) begin
            // R2: lookahead carry agrees with the local full-adder chain
            a_r2_group_carry: assert (cout == ripple_end);
        end
    end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int N = 32,
    parameter int K = 4
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         carry_in,
    output logic [N-1:0] sum,
    output logic         carry_out
);
    localparam int NG = N / K;

    // R9: the width must split into whole groups
    if (N % K != 0) begin : g_bad_split
        $error("cla_adder: N must be a multiple of K");
    end

    logic [NG:0] gc;
    assign gc[0] = carry_in;

    for (genvar j = 0; j < NG; j++) begin : g_grp
        cla_group #(.K(K)) u_grp (
            .xa   (op_a[j*K +: K]),
            .xb   (op_b[j*K +: K]),
            .cin  (gc[j]),
            .s    (sum[j*K +: K]),
            .cout (gc[j+1])
        );
    end

    assign carry_out = gc[NG];

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            // R1: result matches the arithmetic sum
            a_r1_total: assert ({carry_out, sum} ==
                                ({1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in}));
        end
    end
endmodule

// File: tb/cla_adder_test.sv
module cla_adder_test;
    localparam int N = 32;
    localparam int K = 4;

    logic         clk = 1'b0;
    logic [N-1:0] a, b;
    logic         ci;
    logic [N-1:0] s;
    logic         co;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cla_adder #(.N(N), .K(K)) uut (
        .op_a      (a),
        .op_b      (b),
        .carry_in  (ci),
        .sum       (s),
        .carry_out (co)
    );

    task automatic apply(input logic [N-1:0] va, input logic [N-1:0] vb,
                         input logic vc, input string req);
        logic [N:0] want;
        @(posedge clk);
        a  = va;
        b  = vb;
        ci = vc;
        want = {1'b0, va} + {1'b0, vb} + {{N{1'b0}}, vc};
        @(negedge clk);
        checks++;
        if ({co, s} !== want) begin
            errors++;
            $display("FAIL %s a=%h b=%h ci=%0d got co=%0d s=%h expected co=%0d s=%h",
                     req, va, vb, vc, co, s, want[N], want[N-1:0]);
        end
    endtask

    task automatic expect_fixed(input logic [N-1:0] va, input logic [N-1:0] vb,
                                input logic vc, input logic ec,
                                input logic [N-1:0] es, input string req);
        @(posedge clk);
        a  = va;
        b  = vb;
        ci = vc;
        @(negedge clk);
        checks++;
        if (co !== ec || s !== es) begin
            errors++;
            $display("FAIL %s got co=%0d s=%h expected co=%0d s=%h",
                     req, co, s, ec, es);
        end
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        // R8: zero in, zero out
        expect_fixed(32'h0, 32'h0, 1'b0, 1'b0, 32'h0, "R8 zero");
        // R3: full propagate passes carry_in through all groups
        expect_fixed(32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 32'h0, "R3 propagate cin=1");
        expect_fixed(32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 32'hFFFF_FFFF, "R3 propagate cin=0");
        // R4: generate in group 0 crosses into group 1
        expect_fixed(32'h0000_000F, 32'h0000_0001, 1'b0, 1'b0, 32'h0000_0010, "R4 generate boundary");
        expect_fixed(32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0, "R4 generate long run");
        // R5: killing group blocks carry_in
        expect_fixed(32'h0, 32'h0, 1'b1, 1'b0, 32'h1, "R5 kill");
        expect_fixed(32'hFFFF_FF0F, 32'h0, 1'b1, 1'b0, 32'hFFFF_FF10, "R5 kill in group 1");
        // R6: alternating bits
        expect_fixed(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 1'b0, 32'hFFFF_FFFF, "R6 alt cin=0");
        expect_fixed(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 1'b1, 32'h0, "R6 alt cin=1");
        // R7: maximum operands
        expect_fixed(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_FFFE, "R7 max cin=0");
        expect_fixed(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'hFFFF_FFFF, "R7 max cin=1");
        // R2 / R9: carry across every group boundary
        for (int j = 1; j < N / K; j++) begin
            apply((32'h1 << (j*K)) - 32'h1, 32'h1, 1'b0, "R2 boundary carry");
            apply((32'h1 << (j*K)) - 32'h1, 32'h0, 1'b1, "R9 boundary cin");
        end
        // R1: random vectors
        for (int i = 0; i < 3000; i++) begin
            apply($urandom, $urandom, 1'($urandom), "R1 random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule